// File: doc/BRIEF.md
# Single-Channel DMA Mover with Periodic Source Rewind

This block is one memory-to-memory DMA channel. Software loads a starting source address, a fixed destination address and a transfer count. Each transfer reads one item from the source and writes it to the destination. The item can be 1, 2 or 4 bytes. After every transfer the source pointer moves forward by the item size. After the fourth transfer of a group it jumps back to a saved start value. The channel therefore reads the same short four-item block over and over and streams it to one fixed location, as a peripheral data register would need.

Transfers run only while a global enable and a channel enable are both high and the non-maskable interrupt input is low. A hidden group-of-four counter decides when the rewind happens. Disabling the channel, raising the interrupt, reaching the end of the count or detecting an address error clears that counter. None of these events touches the address or count registers.

Software clears the end flag and the error flag together with a single clear strobe.

Top module: `dma_reload_chan`

## Requirements
- R1: `size_sel` selects the item size: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. The value is presented on `mem_size`. After each completed transfer that does not close a group, the source pointer grows by the item size.
- R2: A transfer has two steps. First comes a read (`mem_req`=1, `mem_we`=0) at the source pointer, which finishes when `mem_ack` is seen. Then comes a write (`mem_we`=1) at the destination of the data just read, which finishes when `mem_ack` is seen. Only one access is presented at a time.
- R3: The destination address never changes except by a register write.
- R4: On each rising edge of `chn_en`, the current source pointer is saved. A transfer that completes a group of four loads the saved value back into the source pointer, so the next read uses the start address again.
- R5: The count drops by one on every completed transfer.
- R6: A transfer starts only when `glb_en` and `chn_en` are high, `nmi` is low, both flags are clear and the count is nonzero.
- R7: The end flag is set when a transfer brings the count to zero. While the flag is set, no access is requested. The flag holds until `flag_clr` is pulsed.
- R8: The group counter (`grp_now`) returns to 0 in any of these cases: `glb_en` low, `chn_en` low, `nmi` high, the end flag being set, or an address error.
- R9: An access that is cut off by a disable or `nmi` is dropped. The source, destination and count registers stay unchanged.
- R10: A source or destination address that is not a multiple of the item size, found at the point of starting, sets the error flag. In that case no access is issued and the registers stay unchanged. The flag holds until `flag_clr`.
- R11: After reset, all registers, flags and the group counter are zero and no access is requested.
- R12: Register writes use `cfg_sel`: 0 selects the source, 1 the destination, 2 the count (low bits). Writes with `cfg_sel`=3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| size_sel | input | 2 | Item size code |
| glb_en | input | 1 | Global enable |
| chn_en | input | 1 | Channel enable |
| nmi | input | 1 | Non-maskable interrupt |
| flag_clr | input | 1 | Clears end and error flags |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DW | Read data |
| te_flag | output | 1 | Transfer-end flag |
| ae_flag | output | 1 | Address-error flag |
| src_now | output | AW | Working source pointer |
| dst_now | output | AW | Destination address |
| count_now | output | CW | Remaining transfer count |
| grp_now | output | GW | Position within the group of four |

## Verification
The hardest case to reach is an abort in the middle of a group. After it, the next rewind has to happen four transfers after the restart, not four after the original start. A disable must also re-save the start address from the pointer at the moment of re-enable. The stimulus waits for the count to reach a chosen mid-group value. It then pulses `nmi`, drops `chn_en` or drops `glb_en` while an access may be waiting for its acknowledge, and resumes. An irregular acknowledge pattern makes the aborts land in both read and write phases.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  // Byte count of one item for a size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // True when the low address bits suit the item size.
  function automatic logic addr_ok(input logic [1:0] lsb, input logic [1:0] sz);
    case (sz)
      2'd0:    addr_ok = 1'b1;
      2'd1:    addr_ok = (lsb[0] == 1'b0);
      default: addr_ok = (lsb == 2'b00);
    endcase
  endfunction

endpackage

// File: rtl/dma_rl_regs.sv
module dma_rl_regs #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cap_saved,
  input  logic          xfer_done,
  input  logic          do_reload,
  input  logic [2:0]    step_bytes,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] count,
  output logic [AW-1:0] saved
);

  logic wr_src, wr_dst, wr_cnt;
  assign wr_src = cfg_we && (cfg_sel == 2'd0);
  assign wr_dst = cfg_we && (cfg_sel == 2'd1);
  assign wr_cnt = cfg_we && (cfg_sel == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src   <= '0;
      dst   <= '0;
      count <= '0;
      saved <= '0;
    end else begin
      if (cap_saved) saved <= src;
      if (wr_dst) dst <= cfg_wdata;
      if (wr_src)
        src <= cfg_wdata;
      else if (xfer_done)
        src <= do_reload ? saved : src + AW'(step_bytes);
      if (wr_cnt)
        count <= cfg_wdata[CW-1:0];
      else if (xfer_done)
        count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/dma_rl_group.sv
module dma_rl_group #(
  parameter int GROUP_LEN = 4,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [GW-1:0] grp,
  output logic          last
);

  logic [GW-1:0] grp_inc;

  assign last = (grp == GW'(GROUP_LEN - 1));

  generate
    if ((1 << GW) == GROUP_LEN) begin : g_pow2
      assign grp_inc = grp + GW'(1);
    end else begin : g_cmp
      assign grp_inc = last ? '0 : grp + GW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      grp <= '0;
    else if (clr)
      grp <= '0;
    else if (step)
      grp <= grp_inc;
  end

endmodule

// File: rtl/dma_rl_seq.sv
module dma_rl_seq
  import dma_rl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          may_start,
  input  logic          abort,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [1:0]    size_sel,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          xfer_done,
  output logic          start_bad
);

  phase_t        ph, ph_nx;
  logic [DW-1:0] hold;
  logic          ends_ok;

  assign ends_ok   = addr_ok(src[1:0], size_sel) && addr_ok(dst[1:0], size_sel);
  assign start_bad = (ph == PH_IDLE) && may_start && !ends_ok;
  assign xfer_done = (ph == PH_WRITE) && !abort && mem_ack;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE:  if (may_start && ends_ok) ph_nx = PH_READ;
      PH_READ:  if (abort) ph_nx = PH_IDLE;
                else if (mem_ack) ph_nx = PH_WRITE;
      PH_WRITE: if (abort || mem_ack) ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      hold <= '0;
    end else begin
      ph <= ph_nx;
      if (ph == PH_READ && !abort && mem_ack) hold <= mem_rdata;
    end
  end

  assign mem_req   = (ph != PH_IDLE);
  assign mem_we    = (ph == PH_WRITE);
  assign mem_addr  = (ph == PH_WRITE) ? dst : src;
  assign mem_wdata = hold;

endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_rl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int GROUP_LEN = 4,
  localparam int GW = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [1:0]    size_sel,
  input  logic          glb_en,
  input  logic          chn_en,
  input  logic          nmi,
  input  logic          flag_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          te_flag,
  output logic          ae_flag,
  output logic [AW-1:0] src_now,
  output logic [AW-1:0] dst_now,
  output logic [CW-1:0] count_now,
  output logic [GW-1:0] grp_now
);

  logic          chn_en_q;
  logic          cap_saved, abort, may_start;
  logic          xfer_done, start_bad, te_set, grp_clr, grp_last;
  logic [AW-1:0] saved_src;

  assign cap_saved = chn_en && !chn_en_q;
  assign abort     = !glb_en || !chn_en || nmi;
  assign may_start = !abort && !te_flag && !ae_flag && (count_now != '0);
  assign te_set    = xfer_done && (count_now == CW'(1));
  assign grp_clr   = abort || te_set || start_bad;
  assign mem_size  = size_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chn_en_q <= 1'b0;
      te_flag  <= 1'b0;
      ae_flag  <= 1'b0;
    end else begin
      chn_en_q <= chn_en;
      if (te_set) te_flag <= 1'b1;
      else if (flag_clr) te_flag <= 1'b0;
      if (start_bad) ae_flag <= 1'b1;
      else if (flag_clr) ae_flag <= 1'b0;
    end
  end

  dma_rl_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cap_saved(cap_saved), .xfer_done(xfer_done), .do_reload(grp_last),
    .step_bytes(size_bytes(size_sel)),
    .src(src_now), .dst(dst_now), .count(count_now), .saved(saved_src)
  );

  dma_rl_group #(.GROUP_LEN(GROUP_LEN), .GW(GW)) u_group (
    .clk(clk), .rst_n(rst_n), .clr(grp_clr), .step(xfer_done),
    .grp(grp_now), .last(grp_last)
  );

  dma_rl_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .may_start(may_start), .abort(abort),
    .src(src_now), .dst(dst_now), .size_sel(size_sel),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .xfer_done(xfer_done), .start_bad(start_bad)
  );

endmodule

// File: rtl/dma_reload_chk.sv
module dma_reload_chk
  import dma_rl_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int GW = 2,
  parameter int GROUP_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          chn_en,
  input logic          nmi,
  input logic          cfg_we,
  input logic          flag_clr,
  input logic [1:0]    size_sel,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          te_flag,
  input logic [AW-1:0] src_now,
  input logic [AW-1:0] dst_now,
  input logic [CW-1:0] count_now,
  input logic [GW-1:0] grp_now,
  input logic          xfer_done,
  input logic [AW-1:0] saved_src
);

  AST_DST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(dst_now)); // R3

  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && grp_now == GW'(GROUP_LEN - 1) && !cfg_we) |=> src_now == $past(saved_src)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cfg_we) |=> count_now == $past(count_now) - CW'(1)); // R5

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (te_flag && !flag_clr) |=> te_flag); // R7

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    te_flag |-> !mem_req); // R7

  AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en || !chn_en || nmi) |=> grp_now == '0); // R8

  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!glb_en || !chn_en || nmi) && !cfg_we) |=>
      ($stable(src_now) && $stable(dst_now) && $stable(count_now))); // R9

  AST_ALIGNED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> addr_ok(mem_addr[1:0], size_sel)); // R10

  AST_WE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R2

endmodule

bind dma_reload_chan dma_reload_chk #(
  .AW(AW), .CW(CW), .GW(GW), .GROUP_LEN(GROUP_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chn_en(chn_en), .nmi(nmi),
  .cfg_we(cfg_we), .flag_clr(flag_clr), .size_sel(size_sel),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .te_flag(te_flag), .src_now(src_now), .dst_now(dst_now),
  .count_now(count_now), .grp_now(grp_now), .xfer_done(xfer_done),
  .saved_src(saved_src)
);

// File: tb/dma_reload_chan_test.sv
`timescale 1ns/1ps
module dma_reload_chan_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  size_sel = 2'd0;
  logic        glb_en = 1'b0, chn_en = 1'b0, nmi = 1'b0, flag_clr = 1'b0;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        te_flag, ae_flag;
  logic [31:0] src_now, dst_now;
  logic [15:0] count_now;
  logic [1:0]  grp_now;

  always #5 clk = ~clk;

  dma_reload_chan uut (.*);

  int checks = 0, failures = 0, cycles = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int unsigned m_src, m_dst, m_cnt, m_saved, m_grp, m_ph;
  logic [31:0] m_buf;
  bit m_te, m_ae, prev_c;
  logic [7:0] lf = 8'hA5;

  function automatic int unsigned nbytes(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_saved = 0; m_grp = 0; m_ph = 0;
      m_buf = 0; m_te = 0; m_ae = 0; prev_c = 0; mem_ack = 0;
    end
    // compare design state with the prediction for this cycle
    chk(mem_req == (m_ph != 0), "R2", "mem_req", 32'(mem_req), 32'(m_ph != 0));
    chk(mem_we == (m_ph == 2), "R2", "mem_we", 32'(mem_we), 32'(m_ph == 2));
    if (m_ph == 1) chk(mem_addr == m_src, "R4", "read addr", mem_addr, m_src);
    if (m_ph == 2) begin
      chk(mem_addr == m_dst, "R3", "write addr", mem_addr, m_dst);
      chk(mem_wdata == m_buf, "R2", "write data", mem_wdata, m_buf);
    end
    chk(mem_size == size_sel, "R1", "mem_size", 32'(mem_size), 32'(size_sel));
    chk(src_now == m_src, "R1", "src", src_now, m_src);
    chk(dst_now == m_dst, "R3", "dst", dst_now, m_dst);
    chk(count_now == 16'(m_cnt), "R5", "count", 32'(count_now), m_cnt);
    chk(grp_now == 2'(m_grp), "R8", "group", 32'(grp_now), m_grp);
    chk(te_flag == m_te, "R7", "te", 32'(te_flag), 32'(m_te));
    chk(ae_flag == m_ae, "R10", "ae", 32'(ae_flag), 32'(m_ae));
    if (rst_n) begin
      bit ab, dn, bad, tes;
      int unsigned b;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_ack = mem_req && (lf[0] || lf[1]);
      mem_rdata = (mem_addr * 32'h9E37) ^ 32'h5A5A_0000;
      b = nbytes(size_sel);
      ab = !glb_en || !chn_en || nmi;
      dn = 0; bad = 0;
      if (chn_en && !prev_c) m_saved = m_src;
      prev_c = chn_en;
      if (m_ph == 0) begin
        if (!ab && !m_te && !m_ae && m_cnt != 0) begin
          if ((m_src % b) != 0 || (m_dst % b) != 0) bad = 1;
          else m_ph = 1;
        end
      end else if (ab) m_ph = 0;
      else if (mem_ack) begin
        if (m_ph == 1) begin m_buf = mem_rdata; m_ph = 2; end
        else begin dn = 1; m_ph = 0; end
      end
      tes = dn && m_cnt == 1;
      if (dn) begin
        m_src = (m_grp == 3) ? m_saved : m_src + b;
        m_cnt = m_cnt - 1;
      end
      if (ab || tes || bad) m_grp = 0;
      else if (dn) m_grp = (m_grp + 1) % 4;
      if (tes) m_te = 1; else if (flag_clr) m_te = 0;
      if (bad) m_ae = 1; else if (flag_clr) m_ae = 0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_src = cfg_wdata;
          2'd1: m_dst = cfg_wdata;
          2'd2: m_cnt = 32'(cfg_wdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    step(1);
    cfg_we = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  task automatic setup(input logic [1:0] sz, input logic [31:0] s,
                       input logic [31:0] d, input logic [31:0] c);
    chn_en = 0; step(1);
    size_sel = sz;
    wr(2'd0, s); wr(2'd1, d); wr(2'd2, c);
    step(1);
  endtask

  task automatic wait_te();
    for (int i = 0; i < 2000 && !te_flag; i++) step(1);
  endtask

  task automatic wait_cnt(input int c);
    for (int i = 0; i < 2000 && count_now != 16'(c); i++) step(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    // R11: reset values
    chk(src_now == 0 && dst_now == 0 && count_now == 0 && !te_flag && !ae_flag && !mem_req,
        "R11", "reset state", src_now, 0);
    rst_n = 1; step(1);
    glb_en = 1;

    // R1 R4: 16-bit items, two full groups
    setup(2'd1, 32'h100, 32'h800, 8);
    chn_en = 1; wait_te(); step(1);
    chk(te_flag, "R7", "end flag after count", 32'(te_flag), 1);
    chk(src_now == 32'h100, "R4", "src rewound at end", src_now, 32'h100);
    chk(dst_now == 32'h800, "R3", "dst unchanged", dst_now, 32'h800);
    step(5);
    chk(te_flag && !mem_req, "R7", "flag held, no request", 32'(mem_req), 0);
    pulse_clr(); step(1);
    chk(!te_flag, "R7", "flag cleared", 32'(te_flag), 0);

    // R1: 8-bit items from odd address
    setup(2'd0, 32'h203, 32'h900, 4);
    chn_en = 1; wait_te(); step(1);
    chk(src_now == 32'h203, "R4", "8-bit rewind", src_now, 32'h203);
    pulse_clr();

    // R8 R9: nmi in mid group, 32-bit items
    setup(2'd2, 32'h1000, 32'h2000, 12);
    chn_en = 1; wait_cnt(10);
    nmi = 1; step(3);
    chk(grp_now == 0, "R8", "group cleared by nmi", 32'(grp_now), 0);
    chk(src_now == 32'h1008 && count_now == 10, "R9", "regs kept on nmi", src_now, 32'h1008);
    nmi = 0; wait_te(); step(1);
    chk(src_now == 32'h1008, "R4", "rewind after nmi resume", src_now, 32'h1008);
    pulse_clr();

    // R4 R8: channel disable, re-enable re-saves start
    setup(2'd1, 32'h400, 32'hA00, 8);
    chn_en = 1; wait_cnt(7);
    chn_en = 0; step(2);
    chk(grp_now == 0 && src_now == 32'h402, "R8", "group cleared by channel off", src_now, 32'h402);
    chn_en = 1; wait_te(); step(1);
    chk(src_now == 32'h408, "R4", "resaved start used", src_now, 32'h408);
    pulse_clr();

    // R8 R9: global disable
    setup(2'd2, 32'h3000, 32'h3100, 8);
    chn_en = 1; wait_cnt(5);
    glb_en = 0; step(2);
    chk(grp_now == 0 && count_now == 5, "R9", "global off keeps count", 32'(count_now), 5);
    glb_en = 1; wait_te(); pulse_clr();

    // R10: misaligned source
    setup(2'd2, 32'h102, 32'h200, 4);
    chn_en = 1; step(3);
    chk(ae_flag && !mem_req && count_now == 4, "R10", "src misaligned", 32'(ae_flag), 1);
    chn_en = 0; step(1); pulse_clr(); step(1);
    chk(!ae_flag, "R10", "error flag cleared", 32'(ae_flag), 0);

    // R10: misaligned destination
    setup(2'd1, 32'h100, 32'h301, 4);
    chn_en = 1; step(3);
    chk(ae_flag && src_now == 32'h100, "R10", "dst misaligned", 32'(ae_flag), 1);
    chn_en = 0; step(1); pulse_clr();

    // R12: select 3 ignored
    setup(2'd1, 32'h500, 32'h600, 4);
    wr(2'd3, 32'hDEAD_BEEF); step(1);
    chk(src_now == 32'h500 && dst_now == 32'h600 && count_now == 4, "R12",
        "select 3 ignored", src_now, 32'h500);

    // R6: zero count never starts
    setup(2'd1, 32'h700, 32'h800, 0);
    chn_en = 1; step(6);
    chk(!mem_req && !te_flag, "R6", "zero count idle", 32'(mem_req), 0);
    chn_en = 0; step(2);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule